// File: doc/BRIEF.md
# Two-Wire Serial Slave with Sub-Address Pointer

This block lets a host on a two-wire serial bus read and write a 256-entry, 8-bit register space. The bus lines arrive asynchronously and are oversampled by the system clock. The slave drives the data line through an open-drain enable. A register file sits next to the block. It sees an address equal to the internal sub-address pointer, a write-data byte, a one-cycle write strobe, and a combinational read-data return.

A transfer starts with a START and a 7-bit device address followed by a direction bit. The device address is built from five strap inputs captured while reset is asserted, with the two upper bits zero. In a write, the first data byte normally sets the pointer and later bytes are stored at the pointer. In a read, bytes come from the pointer. The pointer advances by one after every data byte and wraps from 255 to 0. A repeated START keeps the pointer, so a write that sets it can be followed at once by a read. After a read inside the same message, a write continues from the pointer without a pointer byte. A STOP clears the pointer only if the slave was addressed since the previous STOP, so a read opened after a STOP begins at register 0.

Top module: `i2c_regport_slave`

## Requirements
- R1: After reset the SDA pull-down enable is 0, the write strobe is 0 and the pointer (reg_addr) is 0x00.
- R2: The device address is {2'b00, strap_addr} as sampled in the last cycle of reset. A different address gets no acknowledge. After it, the slave drives nothing, writes nothing and leaves the pointer unchanged until the next START.
- R3: The slave acknowledges a matched address and every byte it receives by holding SDA low through the ninth SCL pulse.
- R4: In a write opened after a STOP or reset, and with no read yet in the message, the first data byte loads the pointer and raises no write strobe.
- R5: Each further written byte raises reg_we for exactly one system clock cycle, with reg_addr equal to the pointer and reg_wdata equal to the byte (MSB received first). The pointer then advances by one, and 0xFF advances to 0x00.
- R6: A read shifts out reg_rdata at the pointer, MSB first, with each bit changed while SCL is low. The pointer advances by one after each byte. The next byte is loaded only after the master acknowledges.
- R7: A master NACK after a read byte ends the read, and the slave releases SDA until the next START or STOP.
- R8: A repeated START leaves the pointer unchanged, so a read after a pointer-setting write returns the addressed location.
- R9: Once a read has taken place since the last STOP, a following write stores its first data byte at the pointer instead of loading the pointer.
- R10: A STOP clears the pointer to 0x00 if a matched address was seen since the previous STOP, so a read as the first transfer after a STOP returns register 0 first.
- R11: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are detected on two-flop synchronized lines. The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 5 | Strap pins forming the low device-address bits |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr | output | 8 | Sub-address pointer, register-file index |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register-file content at reg_addr |

## Verification
The risky overlap is at the end of a received byte. On the same SCL falling edge, the slave starts its acknowledge and also either loads the pointer or raises the write strobe, which moves the pointer one cycle later. A read ending on a falling edge also advances the pointer while the slave releases SDA for the master's acknowledge. The bench provokes this by streaming bytes across the 0xFF boundary and by running a read straight after a pointer load behind a repeated START. It judges the result by comparing every strobe against a queue of expected address and data pairs, and every read byte against an expected memory image.

// File: rtl/i2cs_pkg.sv
// Shared types for the two-wire register slave.
// Assumes 8-bit bus bytes and a 7-bit device address.
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or not yet addressed
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // acknowledging the address
        ST_WR,     // shifting in a data byte
        ST_WACK,   // acknowledging a data byte
        ST_RD,     // shifting out a data byte
        ST_RACK,   // waiting for the master's acknowledge
        ST_IGN     // not addressed or read ended: silent
    } slv_state_t;
endpackage

// File: rtl/i2cs_sync.sv
// Brings SCL and SDA into the clock domain and derives the bus events.
// Assumes both lines idle high; reset values match the idle bus so no
// false START or STOP is seen when reset is released.
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] pad_in;
    logic [1:0] synced;
    logic [1:0] prev;

    assign pad_in = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the pad value through the synchronizer stages.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pad_in[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Keep last cycle's synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 2'b11;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2cs_ptr.sv
// Sub-address pointer: clear, load, or advance by one with wrap.
// Assumes the controller never requests two actions in one cycle.
module i2cs_ptr
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              inc_i,
    input  logic              we_i,
    output logic [BYTE_W-1:0] ptr_o
);
    logic [BYTE_W-1:0] ptr_q;

    // Update the pointer according to the controller's request.
    always_ff @(posedge clk) begin
        if (!rst_n)             ptr_q <= '0;
        else if (clr_i)         ptr_q <= '0;
        else if (load_i)        ptr_q <= load_val_i;
        else if (inc_i || we_i) ptr_q <= ptr_q + 1'b1;
    end

    assign ptr_o = ptr_q;

    // R5/R6: an advance moves the pointer by exactly one, modulo 256.
    p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i || inc_i) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/i2cs_fsm.sv
// Transfer controller: address match, byte shifting, acknowledge
// generation, register strobes and pointer requests.
// Assumes bus events from i2cs_sync; SDA drive changes only on SCL fall.
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter int STRAP_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_s,
    input  logic [BYTE_W-1:0]  rdata_i,
    output logic               sda_oe_o,
    output logic               we_o,
    output logic [BYTE_W-1:0]  wdata_o,
    output logic               ptr_clr_o,
    output logic               ptr_load_o,
    output logic [BYTE_W-1:0]  ptr_val_o,
    output logic               ptr_inc_o,
    output logic               matched_o
);
    localparam int PAD_W = DEV_W - STRAP_W;

    slv_state_t        state;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_full;
    logic              rw_q;
    logic              matched;
    logic              read_seen;
    logic              need_ptr;
    logic              mack;
    logic [STRAP_W-1:0] dev_addr;
    logic              addr_hit;

    // Capture the strap pins while reset is held; the last value stays.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_addr <= strap_i;
    end

    assign addr_hit = (shreg[BYTE_W-1:1] == {{PAD_W{1'b0}}, dev_addr});

    // Main sequencer of one bus transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_full  <= 1'b0;
            rw_q       <= 1'b0;
            matched    <= 1'b0;
            read_seen  <= 1'b0;
            need_ptr   <= 1'b0;
            mack       <= 1'b0;
            sda_oe_o   <= 1'b0;
            we_o       <= 1'b0;
            wdata_o    <= '0;
            ptr_clr_o  <= 1'b0;
            ptr_load_o <= 1'b0;
            ptr_val_o  <= '0;
            ptr_inc_o  <= 1'b0;
        end else begin
            we_o       <= 1'b0;
            ptr_clr_o  <= 1'b0;
            ptr_load_o <= 1'b0;
            ptr_inc_o  <= 1'b0;
            if (start_det) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
                sda_oe_o  <= 1'b0;
            end else if (stop_det) begin
                state     <= ST_IDLE;
                sda_oe_o  <= 1'b0;
                ptr_clr_o <= matched;
                matched   <= 1'b0;
                read_seen <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) byte_full <= 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            bit_cnt   <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    matched  <= 1'b1;
                                    rw_q     <= shreg[0];
                                    state    <= ST_AACK;
                                    sda_oe_o <= 1'b1;
                                end else begin
                                    state <= ST_IGN;
                                end
                            end else begin
                                state    <= ST_WACK;
                                sda_oe_o <= 1'b1;
                                if (need_ptr) begin
                                    ptr_load_o <= 1'b1;
                                    ptr_val_o  <= shreg;
                                    need_ptr   <= 1'b0;
                                end else begin
                                    we_o    <= 1'b1;
                                    wdata_o <= shreg;
                                end
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                state     <= ST_RD;
                                shreg     <= rdata_i;
                                sda_oe_o  <= ~rdata_i[BYTE_W-1];
                                read_seen <= 1'b1;
                            end else begin
                                state    <= ST_WR;
                                sda_oe_o <= 1'b0;
                                need_ptr <= ~read_seen;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            state    <= ST_WR;
                            sda_oe_o <= 1'b0;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                state     <= ST_RACK;
                                sda_oe_o  <= 1'b0;
                                ptr_inc_o <= 1'b1;
                                bit_cnt   <= '0;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~shreg[BYTE_W-2];
                                bit_cnt  <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack) begin
                                state    <= ST_RD;
                                shreg    <= rdata_i;
                                sda_oe_o <= ~rdata_i[BYTE_W-1];
                                bit_cnt  <= '0;
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign matched_o = matched;

    // R2/R7: while silent the slave neither drives SDA nor writes.
    p_ign_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGN) |-> (!sda_oe_o && !we_o));

    // R3: SDA is held low for the whole address acknowledge.
    p_addr_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK) |-> sda_oe_o);

    // R5: the write strobe lasts a single cycle.
    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o);

    // R4: a pointer load never coincides with a register write.
    p_load_no_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load_o |-> !we_o);
endmodule

// File: rtl/i2c_regport_slave.sv
// Top of the two-wire register slave: synchronizer, controller and
// sub-address pointer. The register file is outside and reads
// combinationally at reg_addr.
module i2c_regport_slave
    import i2cs_pkg::*;
#(
    parameter int STRAP_W     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_we,
    input  logic [BYTE_W-1:0]  reg_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ptr_clr, ptr_load, ptr_inc, matched;
    logic [BYTE_W-1:0] ptr_val;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_fsm #(.STRAP_W(STRAP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_addr),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_s      (sda_s),
        .rdata_i    (reg_rdata),
        .sda_oe_o   (sda_oe),
        .we_o       (reg_we),
        .wdata_o    (reg_wdata),
        .ptr_clr_o  (ptr_clr),
        .ptr_load_o (ptr_load),
        .ptr_val_o  (ptr_val),
        .ptr_inc_o  (ptr_inc),
        .matched_o  (matched)
    );

    i2cs_ptr u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (ptr_clr),
        .load_i     (ptr_load),
        .load_val_i (ptr_val),
        .inc_i      (ptr_inc),
        .we_i       (reg_we),
        .ptr_o      (reg_addr)
    );

    // R11: the SDA drive only changes after SCL was seen low.
    p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R10: a STOP after a matched address empties the pointer.
    p_stop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && matched) |-> ##2 (reg_addr == '0));
endmodule

// File: tb/sim_i2c_regport_slave.sv
module sim_i2c_regport_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam logic [4:0] STRAP = 5'h15;
    localparam logic [7:0] AW  = {2'b00, STRAP, 1'b0};
    localparam logic [7:0] AR  = {2'b00, STRAP, 1'b1};
    localparam logic [7:0] BAD = 8'h6A;

    logic clk = 0;
    logic rst_n = 0;
    logic scl_m = 1, sda_m = 1;
    logic sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line;
    logic [7:0] rf [256];
    logic [7:0] exp_mem [256];
    logic [15:0] wq [$];
    int n_chk = 0, n_fail = 0, viol = 0;
    logic done = 0;
    logic prev_oe = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = rf[reg_addr];

    i2c_regport_slave u0 (
        .clk(clk), .rst_n(rst_n), .strap_addr(STRAP),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // register file model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) rf[i] <= init_val(i);
        end else if (reg_we) rf[reg_addr] <= reg_wdata;
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for write strobes (R5)
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (wq.size() == 0) check(0, "R2/R4 unexpected write", {reg_addr, reg_wdata}, 0);
            else begin
                logic [15:0] e;
                e = wq.pop_front();
                check({reg_addr, reg_wdata} == e, "R5 write", {reg_addr, reg_wdata}, e);
            end
        end
        if (rst_n && sda_oe != prev_oe && scl_m) viol++;
        prev_oe <= sda_oe;
    end

    task automatic wait_q(int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic push_wr(logic [7:0] a, logic [7:0] d);
        wq.push_back({a, d});
        exp_mem[a] = d;
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wait_q(1);
        sda_m = 0; wait_q(1);
        scl_m = 0; wait_q(1);
    endtask

    task automatic bus_rstart();
        sda_m = 1; wait_q(1);
        scl_m = 1; wait_q(1);
        sda_m = 0; wait_q(1);
        scl_m = 0; wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m = 0; wait_q(1);
        scl_m = 1; wait_q(1);
        sda_m = 1; wait_q(1);
    endtask

    task automatic wb(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(1);
            scl_m = 1; wait_q(2);
            scl_m = 0;
        end
        sda_m = 1; wait_q(1);
        scl_m = 1; wait_q(1);
        ack = ~sda_line; wait_q(1);
        scl_m = 0; wait_q(1);
    endtask

    task automatic rb(input bit mack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wait_q(1);
            scl_m = 1; wait_q(1);
            b[i] = sda_line; wait_q(1);
            scl_m = 0;
        end
        sda_m = ~mack; wait_q(1);
        scl_m = 1; wait_q(2);
        scl_m = 0; @(negedge clk); @(negedge clk);
        sda_m = 1; wait_q(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] rd;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
        check(reg_we == 0, "R1 reg_we", reg_we, 0);
        check(reg_addr == 0, "R1 pointer", reg_addr, 0);

        // mismatched address is ignored (R2)
        bus_start();
        wb(BAD, ack);  check(ack == 0, "R2 no ack on mismatch", ack, 0);
        wb(8'h33, ack); check(ack == 0, "R2 no ack after mismatch", ack, 0);
        check(reg_addr == 0, "R2 pointer kept", reg_addr, 0);
        bus_stop();

        // pointer load then writes (R3, R4, R5), STOP clears (R10)
        bus_start();
        wb(AW, ack);    check(ack == 1, "R3 address ack", ack, 1);
        wb(8'h10, ack); check(ack == 1, "R3 pointer byte ack", ack, 1);
        check(reg_addr == 8'h10, "R4 pointer loaded", reg_addr, 8'h10);
        push_wr(8'h10, 8'hAA); wb(8'hAA, ack); check(ack == 1, "R3 data ack", ack, 1);
        push_wr(8'h11, 8'h55); wb(8'h55, ack);
        check(reg_addr == 8'h12, "R5 pointer advanced", reg_addr, 8'h12);
        bus_stop();
        check(reg_addr == 0, "R10 stop clears pointer", reg_addr, 0);

        // wrap at 0xFF (R5)
        bus_start();
        wb(AW, ack); wb(8'hFF, ack);
        push_wr(8'hFF, 8'h11); wb(8'h11, ack);
        push_wr(8'h00, 8'h22); wb(8'h22, ack);
        check(reg_addr == 8'h01, "R5 pointer wrap", reg_addr, 8'h01);
        bus_stop();

        // combined write-pointer then read (R6, R8), NACK (R7), write after read (R9)
        bus_start();
        wb(AW, ack); wb(8'h20, ack);
        bus_rstart();
        check(reg_addr == 8'h20, "R8 pointer kept over repeated start", reg_addr, 8'h20);
        wb(AR, ack); check(ack == 1, "R3 read address ack", ack, 1);
        rb(1, rd); check(rd == exp_mem[8'h20], "R6 R8 first read byte", rd, exp_mem[8'h20]);
        rb(0, rd); check(rd == exp_mem[8'h21], "R6 second read byte", rd, exp_mem[8'h21]);
        check(reg_addr == 8'h22, "R6 pointer after reads", reg_addr, 8'h22);
        scl_m = 1; wait_q(1);
        check(sda_line == 1 && sda_oe == 0, "R7 released after nack", sda_oe, 0);
        scl_m = 0; wait_q(1);
        bus_rstart();
        wb(AW, ack);
        push_wr(8'h22, 8'h77); wb(8'h77, ack); check(ack == 1, "R9 data ack", ack, 1);
        check(reg_addr == 8'h23, "R9 continued from pointer", reg_addr, 8'h23);
        bus_stop();
        check(reg_addr == 0, "R10 stop clears after combined", reg_addr, 0);

        // read after STOP starts at register 0 (R10)
        bus_start();
        wb(AR, ack);
        rb(0, rd); check(rd == exp_mem[0], "R10 read from register 0", rd, exp_mem[0]);
        bus_stop();

        // mismatch inside a message leaves the pointer alone (R2)
        bus_start();
        wb(AW, ack); wb(8'h40, ack);
        bus_rstart();
        wb(BAD, ack);   check(ack == 0, "R2 mismatch in message", ack, 0);
        wb(8'h99, ack); check(ack == 0, "R2 byte ignored", ack, 0);
        check(reg_addr == 8'h40, "R2 pointer unchanged", reg_addr, 8'h40);
        bus_rstart();
        wb(AR, ack); check(ack == 1, "R2 rematch ack", ack, 1);
        rb(0, rd); check(rd == exp_mem[8'h40], "R2 R8 read after ignore", rd, exp_mem[8'h40]);
        bus_stop();

        repeat (10) @(negedge clk);
        check(wq.size() == 0, "R5 all writes seen", wq.size(), 0);
        check(viol == 0, "R11 SDA changed with SCL high", viol, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule